// File: doc/BRIEF.md
# Cartridge bank-switching register decoder

This block watches CPU writes in the upper 32 KiB of the address space and keeps the mapping state of a cartridge in a set of registers. There are two program registers, eight character registers and one control register. From them it drives, without any clock delay, the bank number for each of four 8 KiB program slots (0x8000, 0xA000, 0xC000, 0xE000) and each of eight 1 KiB character slots. It also drives a two-bit nametable mirroring code and the controls for a work-RAM window at 0x6000–0x7FFF.

The first program register selects a 16 KiB bank. It feeds the two lower program slots, with each slot's own low bit appended. The third slot follows the second program register, and the top slot is fixed at the last bank. Two parameters name the address lines that form the register index, so boards that wire those lines swapped can use the block unchanged. Every bank number leaves through an AND mask and then an OR mask, one pair for program banks and one for character banks. Outer-bank logic can use these masks to restrict the range.

While the control register disables the RAM window, the RAM sees neither a select nor a write strobe. A read in the window instead asks the bus to return the high byte of the address.

Top module: `cart_bank_decoder`

## Requirements
- R1: A register changes only on a rising clock edge where we_i is high and addr_i[15] is 1. The group is addr_i[14:12]. Groups 0 and 4 write program register addr_i[14], so 0x8000 writes register 0 and 0xC000 writes register 1.
- R2: A write to group 1, 2 or 7 changes no output. A write to group 3 whose index is not 3 changes no output. A write with addr_i[15] = 0 changes no register.
- R3: The register index is {addr_i[IDX1_BIT], addr_i[IDX0_BIT]}. The defaults are IDX0_BIT = 0 and IDX1_BIT = 1, and the two parameters may be swapped.
- R4: A write to group 5 or 6 sets character register {addr_i[13], index}. Character slot k appears on chr_bank_o[8k+7:8k] and shows register k.
- R5: Program slot k appears on prg_bank_o[8k+7:8k]. Slot 0 is {reg0[6:0],0}, slot 1 is {reg0[6:0],1}, slot 2 is reg1 and slot 3 is 0xFF, each before masking.
- R6: mirror_o equals control bits [3:2]. The codes are 0 = vertical, 1 = horizontal, 2 = single-screen page 0 and 3 = single-screen page 1.
- R7: The window is addr_i[15:13] = 3'b011. With control bit 7 set, ram_cs_o = we_i|re_i and ram_we_o = we_i inside the window. With bit 7 clear, both stay low, and a read in the window raises ob_en_o with ob_data_o = addr_i[15:8]. Otherwise ob_en_o = 0 and ob_data_o = 0.
- R8: After reset, program register 0 = 0x00, program register 1 = 0xFE, character register k = k, and the control register = 0x00.
- R9: Each program bank output is (raw & PRG_AND_MASK) | PRG_OR_MASK. Each character bank output is (raw & CHR_AND_MASK) | CHR_OR_MASK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| prg_bank_o | output | 32 | Four program slot bank numbers, slot 0 in the low byte |
| chr_bank_o | output | 64 | Eight character slot bank numbers, slot 0 in the low byte |
| mirror_o | output | 2 | Nametable mirroring code |
| ram_cs_o | output | 1 | Work-RAM select |
| ram_we_o | output | 1 | Work-RAM write strobe |
| ob_en_o | output | 1 | Drive open-bus value on the data bus |
| ob_data_o | output | 8 | Open-bus value |

## Verification
Directed writes first hit each register group at its base address. This separates the two program registers and the two halves of the character file, and shows that the appended low bit reaches the right slot. All four mirroring codes are written in turn. RAM accesses are made with the window both enabled and disabled, which tells a gated select apart from the open-bus reply. Writes to ignored groups, to group 3 with the wrong index and below 0x8000 check that nothing moves. A second instance with swapped index lines and non-trivial masks then runs a long pseudo-random address stream next to the first, so that an index or mask fault shows up as a split between the two against the reference model.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned PRG_REGS  = 2;
  localparam int unsigned CHR_REGS  = 8;
  localparam int unsigned PRG_SLOTS = 4;
  localparam int unsigned CHR_SLOTS = CHR_REGS;
  localparam int unsigned CHR_SEL_W = $clog2(CHR_REGS);

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_PAGE0 = 2'd2,
    MIR_PAGE1 = 2'd3
  } mirror_e;

  localparam logic [2:0] GRP_PRG_LO = 3'd0;
  localparam logic [2:0] GRP_CTRL   = 3'd3;
  localparam logic [2:0] GRP_PRG_HI = 3'd4;
  localparam logic [2:0] GRP_CHR_LO = 3'd5;
  localparam logic [2:0] GRP_CHR_HI = 3'd6;
  localparam logic [1:0] CTRL_IDX   = 2'd3;

  typedef struct packed {
    logic                 prg_we;
    logic                 prg_sel;
    logic                 chr_we;
    logic [CHR_SEL_W-1:0] chr_sel;
    logic                 ctrl_we;
  } wr_cmd_t;
endpackage

// File: rtl/cbd_wr_decode.sv
module cbd_wr_decode
  import cart_bank_pkg::*;
#(
  parameter int unsigned IDX0_BIT = 0,
  parameter int unsigned IDX1_BIT = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output wr_cmd_t           cmd_o
);
  logic [1:0] idx;
  logic [2:0] grp;
  logic       unused_addr;

  assign idx         = {addr_i[IDX1_BIT], addr_i[IDX0_BIT]};
  assign grp         = addr_i[14:12];
  assign unused_addr = ^addr_i;

  always_comb begin
    cmd_o = '0;
    if (we_i && addr_i[15]) begin
      unique case (grp)
        GRP_PRG_LO, GRP_PRG_HI: begin
          cmd_o.prg_we  = 1'b1;
          cmd_o.prg_sel = addr_i[14];
        end
        GRP_CTRL: cmd_o.ctrl_we = (idx == CTRL_IDX);
        GRP_CHR_LO, GRP_CHR_HI: begin
          cmd_o.chr_we  = 1'b1;
          cmd_o.chr_sel = {addr_i[13], idx};
        end
        default: cmd_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cbd_regs.sv
module cbd_regs
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PRG1_RST = 'hFE
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  wr_cmd_t                            cmd_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [PRG_REGS-1:0][DATA_W-1:0]    prg_o,
  output logic [CHR_REGS-1:0][DATA_W-1:0]    chr_o,
  output logic [DATA_W-1:0]                  ctrl_o
);
  for (genvar p = 0; p < PRG_REGS; p++) begin : g_prg
    localparam logic [DATA_W-1:0] RST_VAL = (p == 1) ? DATA_W'(PRG1_RST) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            prg_o[p] <= RST_VAL;
      else if (cmd_i.prg_we && (cmd_i.prg_sel == 1'(p)))      prg_o[p] <= wdata_i;
    end
  end

  for (genvar c = 0; c < CHR_REGS; c++) begin : g_chr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            chr_o[c] <= DATA_W'(c);
      else if (cmd_i.chr_we && (cmd_i.chr_sel == CHR_SEL_W'(c))) chr_o[c] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ctrl_o <= '0;
    else if (cmd_i.ctrl_we) ctrl_o <= wdata_i;
  end
endmodule

// File: rtl/cbd_slot_map.sv
module cbd_slot_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned          DATA_W       = 8,
  parameter logic [DATA_W-1:0]    PRG_AND_MASK = '1,
  parameter logic [DATA_W-1:0]    PRG_OR_MASK  = '0,
  parameter logic [DATA_W-1:0]    CHR_AND_MASK = '1,
  parameter logic [DATA_W-1:0]    CHR_OR_MASK  = '0
) (
  input  logic [PRG_REGS-1:0][DATA_W-1:0] prg_i,
  input  logic [CHR_REGS-1:0][DATA_W-1:0] chr_i,
  output logic [PRG_SLOTS*DATA_W-1:0]     prg_bank_o,
  output logic [CHR_SLOTS*DATA_W-1:0]     chr_bank_o
);
  localparam logic [DATA_W-1:0] LAST_BANK = '1;

  for (genvar s = 0; s < PRG_SLOTS; s++) begin : g_prg_slot
    logic [DATA_W-1:0] raw;
    if (s < 2) begin : g_pair
      assign raw = {prg_i[0][DATA_W-2:0], 1'(s)};
    end else if (s == 2) begin : g_mid
      assign raw = prg_i[1];
    end else begin : g_fixed
      assign raw = LAST_BANK;
    end
    assign prg_bank_o[s*DATA_W +: DATA_W] = (raw & PRG_AND_MASK) | PRG_OR_MASK;
  end

  for (genvar c = 0; c < CHR_SLOTS; c++) begin : g_chr_slot
    assign chr_bank_o[c*DATA_W +: DATA_W] = (chr_i[c] & CHR_AND_MASK) | CHR_OR_MASK;
  end
endmodule

// File: rtl/cbd_ram_window.sv
module cbd_ram_window #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [7:0]        addr_hi_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              enable_i,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic              ob_en_o,
  output logic [DATA_W-1:0] ob_data_o
);
  logic in_win;
  assign in_win    = (addr_hi_i[7:5] == 3'b011);
  assign ram_cs_o  = in_win && enable_i && (we_i || re_i);
  assign ram_we_o  = in_win && enable_i && we_i;
  assign ob_en_o   = in_win && !enable_i && re_i;
  // open bus: last byte on the bus was the address high byte
  assign ob_data_o = ob_en_o ? DATA_W'(addr_hi_i) : '0;
endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
  import cart_bank_pkg::*;
#(
  parameter int unsigned       DATA_W       = 8,
  parameter int unsigned       IDX0_BIT     = 0,
  parameter int unsigned       IDX1_BIT     = 1,
  parameter logic [DATA_W-1:0] PRG_AND_MASK = '1,
  parameter logic [DATA_W-1:0] PRG_OR_MASK  = '0,
  parameter logic [DATA_W-1:0] CHR_AND_MASK = '1,
  parameter logic [DATA_W-1:0] CHR_OR_MASK  = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        we_i,
  input  logic                        re_i,
  output logic [PRG_SLOTS*DATA_W-1:0] prg_bank_o,
  output logic [CHR_SLOTS*DATA_W-1:0] chr_bank_o,
  output logic [1:0]                  mirror_o,
  output logic                        ram_cs_o,
  output logic                        ram_we_o,
  output logic                        ob_en_o,
  output logic [DATA_W-1:0]           ob_data_o
);
  localparam int unsigned CTRL_RAM_EN = 7;

  wr_cmd_t                          cmd;
  logic [PRG_REGS-1:0][DATA_W-1:0]  prg_q;
  logic [CHR_REGS-1:0][DATA_W-1:0]  chr_q;
  logic [DATA_W-1:0]                ctrl_q;
  mirror_e                          mirror;

  cbd_wr_decode #(
    .IDX0_BIT (IDX0_BIT),
    .IDX1_BIT (IDX1_BIT)
  ) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .cmd_o  (cmd)
  );

  cbd_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .wdata_i (wdata_i),
    .prg_o   (prg_q),
    .chr_o   (chr_q),
    .ctrl_o  (ctrl_q)
  );

  cbd_slot_map #(
    .DATA_W       (DATA_W),
    .PRG_AND_MASK (PRG_AND_MASK),
    .PRG_OR_MASK  (PRG_OR_MASK),
    .CHR_AND_MASK (CHR_AND_MASK),
    .CHR_OR_MASK  (CHR_OR_MASK)
  ) u_map (
    .prg_i      (prg_q),
    .chr_i      (chr_q),
    .prg_bank_o (prg_bank_o),
    .chr_bank_o (chr_bank_o)
  );

  cbd_ram_window #(
    .DATA_W (DATA_W)
  ) u_win (
    .addr_hi_i (addr_i[15:8]),
    .we_i      (we_i),
    .re_i      (re_i),
    .enable_i  (ctrl_q[CTRL_RAM_EN]),
    .ram_cs_o  (ram_cs_o),
    .ram_we_o  (ram_we_o),
    .ob_en_o   (ob_en_o),
    .ob_data_o (ob_data_o)
  );

  // bit 3: single-screen, bit 2: page / orientation
  assign mirror   = mirror_e'(ctrl_q[3:2]);
  assign mirror_o = mirror;

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_q[6:4], ctrl_q[1:0]};
endmodule

// File: rtl/cart_bank_decoder_chk.sv
module cart_bank_decoder_chk
  import cart_bank_pkg::*;
#(
  parameter int unsigned       DATA_W       = 8,
  parameter int unsigned       IDX0_BIT     = 0,
  parameter int unsigned       IDX1_BIT     = 1,
  parameter logic [DATA_W-1:0] PRG_AND_MASK = '1,
  parameter logic [DATA_W-1:0] PRG_OR_MASK  = '0
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [DATA_W-1:0]           wdata_i,
  input logic                        we_i,
  input logic [PRG_SLOTS*DATA_W-1:0] prg_bank_o,
  input logic [CHR_SLOTS*DATA_W-1:0] chr_bank_o,
  input logic [1:0]                  mirror_o,
  input logic                        ram_cs_o,
  input logic                        ram_we_o,
  input logic                        ob_en_o
);
  logic [1:0] idx;
  logic [2:0] grp;
  logic       hi_wr;
  assign idx   = {addr_i[IDX1_BIT], addr_i[IDX0_BIT]};
  assign grp   = addr_i[14:12];
  assign hi_wr = we_i && addr_i[15];

  assert_low_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i[15]) |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

  assert_ignored_grp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && (grp == 3'd1 || grp == 3'd2 || grp == 3'd7))
    |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

  assert_ctrl_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && grp == 3'd3 && idx != 2'd3) |=> $stable(mirror_o));

  assert_prg_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && grp == 3'd0)
    |=> (prg_bank_o[DATA_W-1:0] ==
         (({$past(wdata_i[DATA_W-2:0]), 1'b0} & PRG_AND_MASK) | PRG_OR_MASK)));

  assert_ram_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && grp == 3'd3 && idx == 2'd3 && !wdata_i[7]) |=> (!ram_cs_o && !ram_we_o));

  assert_ram_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_cs_o, ob_en_o}) && (!ram_we_o || ram_cs_o));
endmodule

bind cart_bank_decoder cart_bank_decoder_chk #(
  .DATA_W       (DATA_W),
  .IDX0_BIT     (IDX0_BIT),
  .IDX1_BIT     (IDX1_BIT),
  .PRG_AND_MASK (PRG_AND_MASK),
  .PRG_OR_MASK  (PRG_OR_MASK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .we_i       (we_i),
  .prg_bank_o (prg_bank_o),
  .chr_bank_o (chr_bank_o),
  .mirror_o   (mirror_o),
  .ram_cs_o   (ram_cs_o),
  .ram_we_o   (ram_we_o),
  .ob_en_o    (ob_en_o)
);

// File: tb/cart_bank_decoder_tb.sv
`timescale 1ns/1ps
module cart_bank_decoder_tb;
  localparam logic [7:0] PAND_B = 8'h0F, POR_B = 8'h40;
  localparam logic [7:0] CAND_B = 8'h3F, COR_B = 8'h80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] addr  = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;

  logic [31:0] prg_a, prg_b;
  logic [63:0] chr_a, chr_b;
  logic [1:0]  mir_a, mir_b;
  logic        cs_a, cs_b, rwe_a, rwe_b, obe_a, obe_b;
  logic [7:0]  obd_a, obd_b;

  cart_bank_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .prg_bank_o(prg_a), .chr_bank_o(chr_a), .mirror_o(mir_a), .ram_cs_o(cs_a),
    .ram_we_o(rwe_a), .ob_en_o(obe_a), .ob_data_o(obd_a));

  cart_bank_decoder #(
    .IDX0_BIT(1), .IDX1_BIT(0),
    .PRG_AND_MASK(PAND_B), .PRG_OR_MASK(POR_B),
    .CHR_AND_MASK(CAND_B), .CHR_OR_MASK(COR_B)
  ) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .prg_bank_o(prg_b), .chr_bank_o(chr_b), .mirror_o(mir_b), .ram_cs_o(cs_b),
    .ram_we_o(rwe_b), .ob_en_o(obe_b), .ob_data_o(obd_b));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_prg [2][2];
  logic [7:0] m_chr [2][8];
  logic [7:0] m_ctrl[2];

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int idx_of(input int inst, input logic [15:0] a);
    return (inst == 0) ? int'({a[1], a[0]}) : int'({a[0], a[1]});
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_prg[i][0] = 8'h00;
      m_prg[i][1] = 8'hFE;
      for (int k = 0; k < 8; k++) m_chr[i][k] = 8'(k);
      m_ctrl[i] = 8'h00;
    end
  endtask

  task automatic model_clock();
    if (we && addr[15]) begin
      for (int i = 0; i < 2; i++) begin
        int g = int'(addr[14:12]);
        int x = idx_of(i, addr);
        if (g == 0 || g == 4)      m_prg[i][int'(addr[14])] = wdata;
        else if (g == 3 && x == 3) m_ctrl[i] = wdata;
        else if (g == 5 || g == 6) m_chr[i][int'(addr[13]) * 4 + x] = wdata;
      end
    end
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < 2; i++) begin
      logic [7:0]  pa = (i == 0) ? 8'hFF : PAND_B;
      logic [7:0]  po = (i == 0) ? 8'h00 : POR_B;
      logic [7:0]  ca = (i == 0) ? 8'hFF : CAND_B;
      logic [7:0]  co = (i == 0) ? 8'h00 : COR_B;
      logic [31:0] ep;
      logic [63:0] ec;
      logic [7:0]  raw [4];
      logic        win, en, ecs, ewe, eob;
      logic [7:0]  eod;
      string       mt = (i == 0) ? "" : " R9 R3";
      raw[0] = {m_prg[i][0][6:0], 1'b0};
      raw[1] = {m_prg[i][0][6:0], 1'b1};
      raw[2] = m_prg[i][1];
      raw[3] = 8'hFF;
      for (int s = 0; s < 4; s++) ep[s*8 +: 8] = (raw[s] & pa) | po;
      for (int k = 0; k < 8; k++) ec[k*8 +: 8] = (m_chr[i][k] & ca) | co;
      win = (addr[15:13] == 3'b011);
      en  = m_ctrl[i][7];
      ecs = win && en && (we || re);
      ewe = win && en && we;
      eob = win && !en && re;
      eod = eob ? addr[15:8] : 8'h00;
      if (i == 0) begin
        check({tag, " R5", mt}, "prg_bank", 64'(prg_a), 64'(ep));
        check({tag, " R4", mt}, "chr_bank", chr_a, ec);
        check({tag, " R6", mt}, "mirror", 64'(mir_a), 64'(m_ctrl[i][3:2]));
        check({tag, " R7", mt}, "ram/openbus", 64'({cs_a, rwe_a, obe_a, obd_a}),
              64'({ecs, ewe, eob, eod}));
      end else begin
        check({tag, " R5", mt}, "prg_bank", 64'(prg_b), 64'(ep));
        check({tag, " R4", mt}, "chr_bank", chr_b, ec);
        check({tag, " R6", mt}, "mirror", 64'(mir_b), 64'(m_ctrl[i][3:2]));
        check({tag, " R7", mt}, "ram/openbus", 64'({cs_b, rwe_b, obe_b, obd_b}),
              64'({ecs, ewe, eob, eod}));
      end
    end
  endtask

  // called at a negedge; returns at the following negedge after comparing
  task automatic cyc(input logic [15:0] a, input logic [7:0] d,
                     input logic w, input logic r, input string tag);
    addr = a; wdata = d; we = w; re = r;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R8");
    check("R8", "prg slot2 reset", 64'(prg_a[23:16]), 64'h00FE);
    rst_n = 1'b1;

    // program registers, both groups (R1)
    cyc(16'h8000, 8'h05, 1'b1, 1'b0, "R1");
    check("R5", "slot1 low bit", 64'(prg_a[15:8]), 64'h0B);
    cyc(16'hC000, 8'h13, 1'b1, 1'b0, "R1");
    cyc(16'h8FFF, 8'hC2, 1'b1, 1'b0, "R1");
    cyc(16'hCABC, 8'h7E, 1'b1, 1'b0, "R1");

    // character registers, all eight addresses
    for (int k = 0; k < 4; k++) cyc(16'hD000 | 16'(k), 8'h20 + 8'(k), 1'b1, 1'b0, "R4");
    for (int k = 0; k < 4; k++) cyc(16'hE000 | 16'(k), 8'hA0 + 8'(k), 1'b1, 1'b0, "R4");
    cyc(16'hD001, 8'h5A, 1'b1, 1'b0, "R3");
    check("R3", "default index 1", 64'(chr_a[15:8]), 64'h5A);
    check("R3", "swapped index 2", 64'(chr_b[23:16]), 64'((8'h5A & CAND_B) | COR_B));

    // all mirroring codes, RAM enabled
    cyc(16'hB003, 8'h80, 1'b1, 1'b0, "R6");
    cyc(16'hB003, 8'h84, 1'b1, 1'b0, "R6");
    cyc(16'hB003, 8'h88, 1'b1, 1'b0, "R6");
    cyc(16'hB003, 8'h8C, 1'b1, 1'b0, "R6");
    check("R6", "single page 1", 64'(mir_a), 64'd3);

    // ignored writes
    cyc(16'h9000, 8'hFF, 1'b1, 1'b0, "R2");
    cyc(16'hA123, 8'hFF, 1'b1, 1'b0, "R2");
    cyc(16'hF003, 8'hFF, 1'b1, 1'b0, "R2");
    cyc(16'hB000, 8'h00, 1'b1, 1'b0, "R2");
    cyc(16'hB001, 8'h00, 1'b1, 1'b0, "R2");
    cyc(16'hB002, 8'h00, 1'b1, 1'b0, "R2");
    cyc(16'h4000, 8'h00, 1'b1, 1'b0, "R2");
    cyc(16'h0003, 8'h00, 1'b1, 1'b0, "R2");
    check("R2", "mirror kept", 64'(mir_a), 64'd3);
    cyc(16'h8000, 8'h33, 1'b0, 1'b1, "R2");

    // RAM window enabled then disabled
    cyc(16'h6000, 8'h11, 1'b1, 1'b0, "R7");
    check("R7", "ram write strobe", 64'(rwe_a), 64'd1);
    cyc(16'h7FFF, 8'h00, 1'b0, 1'b1, "R7");
    cyc(16'h5FFF, 8'h00, 1'b0, 1'b1, "R7");
    cyc(16'hB003, 8'h00, 1'b1, 1'b0, "R7");
    cyc(16'h6000, 8'h22, 1'b1, 1'b0, "R7");
    check("R7", "write dropped", 64'({cs_a, rwe_a}), 64'd0);
    cyc(16'h7ABC, 8'h00, 1'b0, 1'b1, "R7");
    check("R7", "open bus byte", 64'({obe_a, obd_a}), 64'h17A);
    cyc(16'h8000, 8'h00, 1'b0, 1'b1, "R7");

    // pseudo-random stream, biased to the decoded half
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      a = lfsr[15:0];
      if (lfsr[31:30] != 2'b00) a[15] = 1'b1;
      if (lfsr[29:28] == 2'b00) a[15:13] = 3'b011;
      cyc(a, lfsr[23:16], lfsr[24], lfsr[25], "rnd R1");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule